// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block models the control logic of a byte-wide NOR flash. A host issues single-cycle byte writes and reads on a synchronous bus. Commands are recognised only after a two-write unlock handshake: AAh to address 5555h, then 55h to address 2AAAh. After that prefix, one more command write selects byte program, product identification entry or exit, or an erase group. The erase group needs a second unlock prefix and then a final write that picks chip erase, sector erase or boot-block lockout. The storage is an on-chip register array. Its seven regions keep the relative sizes of a 256 KB part, with one size unit scaled down to `UNIT_BYTES` bytes.

Program and erase start a busy period whose length is set by a cycle counter (`PROG_CYC` or `ERASE_CYC`). While the block is busy, every read returns a status byte instead of array data. Bit 7 of that byte is the complement of bit 7 of the data being written; erase counts as writing FFh. Bit 6 flips on every read. Bits 5:0 are zero. Once the busy period ends, reads return array data again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is not busy, not locked and not in identification mode. Every array byte reads FFh.
- R2: Byte program is the unlock prefix, then A0h to 5555h, then one write of address and data. The stored byte becomes the AND of its old value and the written data.
- R3: A write that does not match the next expected step of a sequence returns the interpreter to idle and leaves the array unchanged. A command byte written without its prefix has no effect.
- R4: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the target data (0 during erase). Bits 5:0 are 0.
- R5: Bit 6 of the status byte changes value on each successive read while busy. Once the operation completes, reads return the true stored byte, and repeated reads give the same value.
- R6: Sector erase is prefix, 80h to 5555h, prefix, then 30h written to any address inside the target region. It sets only that region to FFh. Regions in units from index 0: 8, 8, 8, 4, 1, 1, 2 (boot, at the top).
- R7: Chip erase is prefix, 80h to 5555h, prefix, then 10h to 5555h. It sets the whole array to FFh, except the boot region when lockout is set.
- R8: Prefix then 90h to 5555h enters identification mode. In that mode a read returns `MFR_ID` when address bit 0 is 0 and `DEV_ID` when it is 1. Prefix then F0h to 5555h returns to array reads.
- R9: Prefix, 80h, prefix, then 40h to 5555h sets boot lockout, which stays set until reset. After that, program and sector erase aimed at the boot region are ignored and do not start a busy period.
- R10: Writes that arrive while busy are ignored and do not advance any sequence.
- R11: A program gives exactly `PROG_CYC` consecutive reads that return status, and an erase gives exactly `ERASE_CYC`. The status reads start on the cycle after the final command write.
- R12: A read issued in the same cycle as a command's final write returns the array byte as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| rd_en | input | 1 | Byte read strobe; data appears on `rdata` one cycle later |
| addr | input | AW | Byte address; low bits index the array, full width is compared for 5555h/2AAAh |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, status byte or identification code |

## Verification
A read and the final write of a command can fall in the same clock cycle. That same edge decides the returned byte and also starts the busy period. The bench provokes this by asserting `rd_en` and `wr_en` together on the program's data write to a fresh byte. It expects the old FFh back, and it expects the next read to return a status byte whose bit 7 is the complement of the new data. A second overlap, writes arriving while the timer runs, is provoked by issuing a whole program sequence during a busy period and then confirming that the target byte is still FFh.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_ERA,
        SQ_ERA_KEY1,
        SQ_ERA_KEY2
    } seq_e;

    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
    localparam logic [7:0] OP_CHIP     = 8'h10;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_LOCK     = 8'h40;
endpackage

// File: rtl/fcs_sector_map.sv
module fcs_sector_map #(
    parameter int UNIT_BYTES = 2,
    parameter int DEPTH      = 32 * UNIT_BYTES,
    parameter int IW         = $clog2(DEPTH)
) (
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] lo,
    output logic [IW-1:0] hi,
    output logic          in_boot
);
    int unit;
    int lo_u;
    int hi_u;

    always_comb begin
        unit = int'(idx) / UNIT_BYTES;
        if (unit < 8) begin
            lo_u = 0;  hi_u = 7;
        end else if (unit < 16) begin
            lo_u = 8;  hi_u = 15;
        end else if (unit < 24) begin
            lo_u = 16; hi_u = 23;
        end else if (unit < 28) begin
            lo_u = 24; hi_u = 27;
        end else if (unit == 28) begin
            lo_u = 28; hi_u = 28;
        end else if (unit == 29) begin
            lo_u = 29; hi_u = 29;
        end else begin
            lo_u = 30; hi_u = 31;
        end
        lo      = IW'(lo_u * UNIT_BYTES);
        hi      = IW'((hi_u + 1) * UNIT_BYTES - 1);
        in_boot = (lo_u == 30);
    end
endmodule

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign cnt  = cnt_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int         AW         = 16,
    parameter int         UNIT_BYTES = 2,
    parameter int         PROG_CYC   = 6,
    parameter int         ERASE_CYC  = 12,
    parameter logic [7:0] MFR_ID     = 8'hDA,
    parameter logic [7:0] DEV_ID     = 8'h8C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH      = 32 * UNIT_BYTES;
    localparam int IW         = $clog2(DEPTH);
    localparam int BOOT_BYTES = 2 * UNIT_BYTES;
    localparam int BOOT_LO    = DEPTH - BOOT_BYTES;
    localparam int CMAX       = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW         = $clog2(CMAX + 1);

    typedef struct packed {
        seq_e                   seq;
        logic [DEPTH-1:0][7:0]  mem;
        logic                   lock;
        logic                   idm;
        logic                   tgt7;
        logic                   tog;
        logic [7:0]             rdata;
    } st_t;

    st_t           q, n;
    logic          busy;
    logic [CW-1:0] cnt;
    logic          t_start;
    logic [CW-1:0] t_len;
    logic [IW-1:0] idx, sec_lo, sec_hi;
    logic          in_boot;
    logic          at_5555, at_2aaa;

    assign idx     = addr[IW-1:0];
    assign at_5555 = (addr == AW'(16'h5555));
    assign at_2aaa = (addr == AW'(16'h2AAA));

    fcs_sector_map #(.UNIT_BYTES(UNIT_BYTES), .DEPTH(DEPTH), .IW(IW)) u_map (
        .idx    (idx),
        .lo     (sec_lo),
        .hi     (sec_hi),
        .in_boot(in_boot)
    );

    fcs_busy_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(t_start),
        .len  (t_len),
        .busy (busy),
        .cnt  (cnt)
    );

    always_comb begin
        n       = q;
        t_start = 1'b0;
        t_len   = CW'(PROG_CYC);

        if (rd_en) begin
            if (busy) begin
                n.rdata = {~q.tgt7, q.tog, 6'b0};
                n.tog   = ~q.tog;
            end else if (q.idm) begin
                n.rdata = idx[0] ? DEV_ID : MFR_ID;
            end else begin
                n.rdata = q.mem[idx];
            end
        end

        if (wr_en && !busy) begin
            n.seq = SQ_IDLE;
            unique case (q.seq)
                SQ_IDLE:     if (at_5555 && wdata == KEY_A) n.seq = SQ_KEY1;
                SQ_KEY1:     if (at_2aaa && wdata == KEY_B) n.seq = SQ_KEY2;
                SQ_KEY2: begin
                    if (at_5555) begin
                        case (wdata)
                            OP_PROGRAM:  n.seq = SQ_PROG;
                            OP_ERASE:    n.seq = SQ_ERA;
                            OP_ID_ENTER: n.idm = 1'b1;
                            OP_ID_LEAVE: n.idm = 1'b0;
                            default:     n.seq = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PROG: begin
                    if (!(in_boot && q.lock)) begin
                        n.mem[idx] = q.mem[idx] & wdata;
                        n.tgt7     = wdata[7];
                        t_start    = 1'b1;
                        t_len      = CW'(PROG_CYC);
                    end
                end
                SQ_ERA:      if (at_5555 && wdata == KEY_A) n.seq = SQ_ERA_KEY1;
                SQ_ERA_KEY1: if (at_2aaa && wdata == KEY_B) n.seq = SQ_ERA_KEY2;
                SQ_ERA_KEY2: begin
                    if (at_5555 && wdata == OP_CHIP) begin
                        for (int i = 0; i < DEPTH; i++)
                            if (!(q.lock && i >= BOOT_LO)) n.mem[i] = 8'hFF;
                        n.tgt7  = 1'b1;
                        t_start = 1'b1;
                        t_len   = CW'(ERASE_CYC);
                    end else if (at_5555 && wdata == OP_LOCK) begin
                        n.lock = 1'b1;
                    end else if (wdata == OP_SECTOR && !(in_boot && q.lock)) begin
                        for (int i = 0; i < DEPTH; i++)
                            if (i >= int'(sec_lo) && i <= int'(sec_hi)) n.mem[i] = 8'hFF;
                        n.tgt7  = 1'b1;
                        t_start = 1'b1;
                        t_len   = CW'(ERASE_CYC);
                    end
                end
                default:     n.seq = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.seq   <= SQ_IDLE;
            q.mem   <= '1;
            q.lock  <= 1'b0;
            q.idm   <= 1'b0;
            q.tgt7  <= 1'b0;
            q.tog   <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= n;
        end
    end

    assign rdata = q.rdata;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int DEPTH      = 64,
    parameter int BOOT_BYTES = 4,
    parameter int CW         = 4,
    parameter int CMAX       = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic                  busy,
    input logic                  lock,
    input logic [CW-1:0]         cnt,
    input logic [7:0]            rdata,
    input logic [DEPTH-1:0][7:0] mem
);
    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(mem));

    // R9
    boot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem[DEPTH-1:DEPTH-BOOT_BYTES]));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R4
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata[5:0] == 6'b0));

    // R11
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= CMAX);
endmodule

bind flash_cmd_seq fcs_checker #(
    .DEPTH(DEPTH), .BOOT_BYTES(BOOT_BYTES), .CW(CW), .CMAX(CMAX)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .busy (busy),
    .lock (q.lock),
    .cnt  (cnt),
    .rdata(rdata),
    .mem  (q.mem)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        unlock(); wr(16'h5555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_final(input logic [15:0] a, input logic [7:0] op);
        unlock(); wr(16'h5555, 8'h80); unlock(); wr(a, op);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rdata after reset", rdata, 8'h00);
        rd(16'h0000, v); check("R1 byte 0 erased", v, 8'hFF);
        rd(16'h003F, v); check("R1 top byte erased", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] v;
        prog(16'h0003, 8'hA5); idle(PROG_CYC + 1);
        rd(16'h0003, v); check("R2 first program", v, 8'hA5);
        prog(16'h0003, 8'h3C); idle(PROG_CYC + 1);
        rd(16'h0003, v); check("R2 AND of old and new", v, 8'h24);
    endtask

    task automatic t_status();
        logic [7:0] v, prev;
        int nstat = 0;
        prog(16'h0005, 8'h80);
        for (int i = 0; i < PROG_CYC + 1; i++) begin
            rd(16'h0005, v);
            if (v[5:0] == 6'b0 && v[7] == 1'b0) begin
                nstat++;
                if (i == 0) check("R4 status bit7 complement, low bits zero", v & 8'hBF, 8'h00);
                if (i > 0) check("R5 bit6 toggles", v[6] ^ prev[6], 1'b1);
                prev = v;
            end else begin
                check("R5 true data after completion", v, 8'h80);
            end
        end
        check("R11 program status read count", 8'(nstat), 8'(PROG_CYC));
        rd(16'h0005, v); check("R5 no toggle after done, read 1", v, 8'h80);
        rd(16'h0005, v); check("R5 no toggle after done, read 2", v, 8'h80);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        unlock(); wr(16'h5555, 8'hA0);
        wr_en = 1'b1; rd_en = 1'b1; addr = 16'h0007; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R12 read with final write sees old byte", rdata, 8'hFF);
        rd(16'h0007, v); check("R4 status bit7 set for data bit7=0", v & 8'hBF, 8'h80);
        idle(PROG_CYC + 1);
        rd(16'h0007, v); check("R2 programmed zero", v, 8'h00);
    endtask

    task automatic t_break();
        logic [7:0] v;
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h33);
        wr(16'h5555, 8'hA0); wr(16'h0009, 8'h00);
        rd(16'h0009, v); check("R3 wrong command byte", v, 8'hFF);
        wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0009, 8'h00);
        rd(16'h0009, v); check("R3 wrong prefix address", v, 8'hFF);
    endtask

    task automatic t_busy_writes();
        logic [7:0] v;
        prog(16'h000A, 8'h0F);
        prog(16'h000B, 8'h00);
        idle(PROG_CYC + 1);
        rd(16'h000B, v); check("R10 write during busy ignored", v, 8'hFF);
        rd(16'h000A, v); check("R10 original program kept", v, 8'h0F);
    endtask

    task automatic t_sector();
        logic [7:0] v;
        prog(16'h0014, 8'h11); idle(PROG_CYC + 1);
        prog(16'h000F, 8'h22); idle(PROG_CYC + 1);
        prog(16'h0020, 8'h33); idle(PROG_CYC + 1);
        erase_final(16'h0014, 8'h30);
        rd(16'h0014, v); check("R4 erase status bit7 zero", v & 8'hBF, 8'h00);
        idle(ERASE_CYC + 1);
        rd(16'h0014, v); check("R6 target region erased", v, 8'hFF);
        rd(16'h000F, v); check("R6 lower neighbour kept", v, 8'h22);
        rd(16'h0020, v); check("R6 upper neighbour kept", v, 8'h33);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        unlock(); wr(16'h5555, 8'h90);
        rd(16'h0000, v); check("R8 manufacturer code", v, 8'hDA);
        rd(16'h0001, v); check("R8 device code", v, 8'h8C);
        unlock(); wr(16'h5555, 8'hF0);
        rd(16'h0003, v); check("R8 array read after exit", v, 8'h24);
    endtask

    task automatic t_lock_chip();
        logic [7:0] v;
        int nstat = 0;
        prog(16'h003E, 8'h12); idle(PROG_CYC + 1);
        erase_final(16'h5555, 8'h40);
        prog(16'h003D, 8'h00);
        rd(16'h003D, v); check("R9 locked program starts no busy", v, 8'hFF);
        erase_final(16'h003E, 8'h30);
        rd(16'h003E, v); check("R9 locked sector erase ignored", v, 8'h12);
        erase_final(16'h5555, 8'h10);
        for (int i = 0; i < ERASE_CYC + 1; i++) begin
            rd(16'h0003, v);
            if (v[5:0] == 6'b0 && v[7] == 1'b0 && v != 8'h00 || (v == 8'h00 && i < ERASE_CYC)) nstat++;
            else if (v == 8'h40 && i < ERASE_CYC) nstat++;
        end
        check("R11 erase status read count", 8'(nstat), 8'(ERASE_CYC));
        rd(16'h0003, v); check("R7 chip erase clears main array", v, 8'hFF);
        rd(16'h0007, v); check("R7 chip erase clears zero byte", v, 8'hFF);
        rd(16'h003E, v); check("R9 chip erase keeps locked boot", v, 8'h12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_program();
        t_status();
        t_same_cycle();
        t_break();
        t_busy_writes();
        t_sector();
        t_ident();
        t_lock_chip();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule